// File: doc/BRIEF.md
# Packed Calendar Counter with Alarms

This block keeps wall-clock time as one 32-bit word. The word holds four fields: a day count, hours, minutes and seconds. Each one-cycle pulse on the tick input moves the time forward by one second. Carries ripple upward through the fields. Every tick produces one-cycle event pulses: one for the second that elapsed, and one for each field that rolled over.

A time word loaded by software replaces the running value and produces no events. A separate alarm word is compared against the freshly advanced time in two ways:
- a time-of-day match, which looks only at hours, minutes and seconds;
- a full match, which also requires the day count to be equal.

Each kind of match raises its own one-cycle pulse.

The block is used next to a prescaler that supplies the once-per-second tick. It leaves register access, write synchronisation and interrupt masking to the logic around it.

Top module: `cal_clock_top`

## Requirements
- R1: After reset, the time word reads 0 and every event output is low.
- R2: The time word is packed with the day in bits 31:17 (15 bits), hours in 16:12, minutes in 11:6 and seconds in 5:0. A tick without a load adds one to the seconds, and `secEvt` pulses high for the cycle after that tick.
- R3: When the seconds field is at 59 on a tick, it becomes 0, the minutes field gains one, and `minEvt` pulses together with `secEvt`.
- R4: When the minutes also carry out of 59, they become 0, the hours gain one, and `hourEvt` pulses.
- R5: When the hours also carry out of 23, they become 0, the day gains one, and `dayEvt` pulses.
- R6: The day field wraps from 32767 to 0 with no event beyond those of R2 to R5.
- R7: On a tick, a seconds, minutes or hours field that holds a value above its maximum (59, 59 or 23) wraps to 0 and carries, as if it held the maximum.
- R8: `todAlarmEvt` pulses for one cycle after a tick when bits 16:0 of the updated time equal bits 16:0 of the alarm word.
- R9: `dayAlarmEvt` pulses for one cycle after a tick when all 32 bits of the updated time equal the alarm word. It therefore never pulses without `todAlarmEvt`.
- R10: Every event output is a single-cycle pulse. Each event is produced only by a tick, and no output pulses in a cycle that follows no tick.
- R11: `loadTimeEn` replaces the time word with `loadTimeVal` at the next edge and takes priority over a tick in the same cycle. The load raises no event, even when the loaded value equals the alarm word.
- R12: Without a tick or a time load, the time word holds its value, and loading the alarm word leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | One-cycle pulse that advances the time by one second |
| loadTimeEn | input | 1 | Strobe that replaces the time word |
| loadTimeVal | input | 32 | Time word to load |
| loadAlarmEn | input | 1 | Strobe that replaces the alarm word |
| loadAlarmVal | input | 32 | Alarm word to load |
| timeOut | output | 32 | Current packed time word |
| secEvt | output | 1 | Pulse: a second elapsed |
| minEvt | output | 1 | Pulse: the seconds rolled over |
| hourEvt | output | 1 | Pulse: the minutes rolled over |
| dayEvt | output | 1 | Pulse: the hours rolled over |
| todAlarmEvt | output | 1 | Pulse: the updated time of day matches the alarm |
| dayAlarmEvt | output | 1 | Pulse: the full updated word matches the alarm |

## Verification
Every result is due exactly one clock edge after its cause:
- a tick or load at edge N shows its new time word and its event pulses from edge N to edge N+1;
- the pulses are gone again after edge N+2.

The bench drives inputs on the falling edge and holds them for a single cycle. It checks the time word and all six event outputs on the falling edge that follows the capturing rising edge. It samples once more one cycle later to confirm that the pulses have cleared. Loads are checked in the same way: the loaded value must appear on the next falling edge, with all events low.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 15;
  localparam int SEC_MAX  = 59;
  localparam int MIN_MAX  = 59;
  localparam int HOUR_MAX = 23;
  localparam int TOD_W  = SEC_W + MIN_W + HOUR_W;
  localparam int WORD_W = TOD_W + DAY_W;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTime;
    logic advance;
    logic wrapSec;
    logic wrapMin;
    logic wrapHour;
    logic wrapDay;
  } calStrobes_t;
endpackage

// File: rtl/cal_field.sv
module cal_field #(
  parameter int W    = 6,
  parameter int MAXV = 59
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadEn,
  input  logic [W-1:0] loadVal,
  input  logic         incEn,
  input  logic         wrapEn,
  output logic         atMax,
  output logic [W-1:0] value,
  output logic [W-1:0] nextVal
);
  localparam logic [W-1:0] MAX_L = W'(MAXV);

  // a value beyond the limit behaves like the limit
  assign atMax = (value >= MAX_L);

  always_comb begin
    if (loadEn)      nextVal = loadVal;
    else if (wrapEn) nextVal = '0;
    else if (incEn)  nextVal = value + W'(1);
    else             nextVal = value;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) value <= '0;
    else       value <= nextVal;
  end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic        loadTimeEn,
  input  logic        secAtMax,
  input  logic        minAtMax,
  input  logic        hourAtMax,
  input  logic        dayAtMax,
  output calStrobes_t strobes,
  output logic        secEvt,
  output logic        minEvt,
  output logic        hourEvt,
  output logic        dayEvt
);
  always_comb begin
    strobes          = '0;
    strobes.loadTime = loadTimeEn;
    strobes.advance  = tickIn && !loadTimeEn;
    strobes.wrapSec  = strobes.advance && secAtMax;
    strobes.wrapMin  = strobes.wrapSec && minAtMax;
    strobes.wrapHour = strobes.wrapMin && hourAtMax;
    strobes.wrapDay  = strobes.wrapHour && dayAtMax;
  end

  // day wrap raises nothing beyond the hour rollover event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secEvt  <= 1'b0;
      minEvt  <= 1'b0;
      hourEvt <= 1'b0;
      dayEvt  <= 1'b0;
    end else begin
      secEvt  <= strobes.advance;
      minEvt  <= strobes.wrapSec;
      hourEvt <= strobes.wrapMin;
      dayEvt  <= strobes.wrapHour;
    end
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobes_t       strobes,
  input  logic [WORD_W-1:0] loadTimeVal,
  input  logic              loadAlarmEn,
  input  logic [WORD_W-1:0] loadAlarmVal,
  output logic              secAtMax,
  output logic              minAtMax,
  output logic              hourAtMax,
  output logic              dayAtMax,
  output logic [WORD_W-1:0] timeWord,
  output logic [WORD_W-1:0] alarmWord,
  output logic              todAlarmEvt,
  output logic              dayAlarmEvt
);
  localparam int MIN_LO  = SEC_W;
  localparam int HOUR_LO = SEC_W + MIN_W;
  localparam int DAY_LO  = TOD_W;
  localparam int DAY_MAX = (1 << DAY_W) - 1;

  logic [SEC_W-1:0]  secQ, secNext;
  logic [MIN_W-1:0]  minQ, minNext;
  logic [HOUR_W-1:0] hourQ, hourNext;
  logic [DAY_W-1:0]  dayQ, dayNext;
  logic [WORD_W-1:0] nextWord;
  logic              todHit, fullHit;

  cal_field #(.W(SEC_W), .MAXV(SEC_MAX)) uSec (
    .clk(clk), .rstN(rstN), .loadEn(strobes.loadTime),
    .loadVal(loadTimeVal[MIN_LO-1:0]),
    .incEn(strobes.advance), .wrapEn(strobes.wrapSec),
    .atMax(secAtMax), .value(secQ), .nextVal(secNext));

  cal_field #(.W(MIN_W), .MAXV(MIN_MAX)) uMin (
    .clk(clk), .rstN(rstN), .loadEn(strobes.loadTime),
    .loadVal(loadTimeVal[HOUR_LO-1:MIN_LO]),
    .incEn(strobes.wrapSec), .wrapEn(strobes.wrapMin),
    .atMax(minAtMax), .value(minQ), .nextVal(minNext));

  cal_field #(.W(HOUR_W), .MAXV(HOUR_MAX)) uHour (
    .clk(clk), .rstN(rstN), .loadEn(strobes.loadTime),
    .loadVal(loadTimeVal[DAY_LO-1:HOUR_LO]),
    .incEn(strobes.wrapMin), .wrapEn(strobes.wrapHour),
    .atMax(hourAtMax), .value(hourQ), .nextVal(hourNext));

  cal_field #(.W(DAY_W), .MAXV(DAY_MAX)) uDay (
    .clk(clk), .rstN(rstN), .loadEn(strobes.loadTime),
    .loadVal(loadTimeVal[WORD_W-1:DAY_LO]),
    .incEn(strobes.wrapHour), .wrapEn(strobes.wrapDay),
    .atMax(dayAtMax), .value(dayQ), .nextVal(dayNext));

  assign timeWord = {dayQ, hourQ, minQ, secQ};
  assign nextWord = {dayNext, hourNext, minNext, secNext};

  // compare the word the tick is about to produce
  assign todHit  = (nextWord[TOD_W-1:0] == alarmWord[TOD_W-1:0]);
  assign fullHit = todHit && (nextWord[WORD_W-1:DAY_LO] == alarmWord[WORD_W-1:DAY_LO]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmWord   <= '0;
      todAlarmEvt <= 1'b0;
      dayAlarmEvt <= 1'b0;
    end else begin
      if (loadAlarmEn) alarmWord <= loadAlarmVal;
      todAlarmEvt <= strobes.advance && todHit;
      dayAlarmEvt <= strobes.advance && fullHit;
    end
  end
endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
  import cal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic        loadTimeEn,
  input  logic [31:0] loadTimeVal,
  input  logic        loadAlarmEn,
  input  logic [31:0] loadAlarmVal,
  output logic [31:0] timeOut,
  output logic        secEvt,
  output logic        minEvt,
  output logic        hourEvt,
  output logic        dayEvt,
  output logic        todAlarmEvt,
  output logic        dayAlarmEvt
);
  calStrobes_t       strobes;
  logic              secAtMax, minAtMax, hourAtMax, dayAtMax;
  logic [WORD_W-1:0] alarmWord;

  cal_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .loadTimeEn(loadTimeEn),
    .secAtMax(secAtMax), .minAtMax(minAtMax), .hourAtMax(hourAtMax),
    .dayAtMax(dayAtMax), .strobes(strobes),
    .secEvt(secEvt), .minEvt(minEvt), .hourEvt(hourEvt), .dayEvt(dayEvt));

  cal_datapath uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .loadTimeVal(loadTimeVal), .loadAlarmEn(loadAlarmEn),
    .loadAlarmVal(loadAlarmVal),
    .secAtMax(secAtMax), .minAtMax(minAtMax), .hourAtMax(hourAtMax),
    .dayAtMax(dayAtMax), .timeWord(timeOut), .alarmWord(alarmWord),
    .todAlarmEvt(todAlarmEvt), .dayAlarmEvt(dayAlarmEvt));
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker (
  input logic        clk,
  input logic        rstN,
  input logic        tickIn,
  input logic        loadTimeEn,
  input logic [31:0] loadTimeVal,
  input logic [31:0] timeOut,
  input logic [31:0] alarmWord,
  input logic        secEvt,
  input logic        minEvt,
  input logic        hourEvt,
  input logic        dayEvt,
  input logic        todAlarmEvt,
  input logic        dayAlarmEvt
);
  a_r12_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn && !loadTimeEn) |=> $stable(timeOut));

  a_r11_load_value: assert property (@(posedge clk) disable iff (!rstN)
    loadTimeEn |=> (timeOut == $past(loadTimeVal)));

  a_r11_load_silent: assert property (@(posedge clk) disable iff (!rstN)
    loadTimeEn |=> !(secEvt || minEvt || hourEvt || dayEvt || todAlarmEvt || dayAlarmEvt));

  a_r2_sec_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !loadTimeEn) |=> secEvt);

  a_r10_no_tick_no_event: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn |=> !(secEvt || minEvt || hourEvt || dayEvt || todAlarmEvt || dayAlarmEvt));

  a_r3_min_needs_sec: assert property (@(posedge clk) disable iff (!rstN)
    minEvt |-> (secEvt && timeOut[5:0] == 6'd0));

  a_r5_day_rollover: assert property (@(posedge clk) disable iff (!rstN)
    dayEvt |-> (hourEvt && timeOut[16:12] == 5'd0));

  a_r8_tod_match: assert property (@(posedge clk) disable iff (!rstN)
    todAlarmEvt |-> (timeOut[16:0] == $past(alarmWord[16:0])));

  a_r9_full_implies_tod: assert property (@(posedge clk) disable iff (!rstN)
    dayAlarmEvt |-> (todAlarmEvt && timeOut == $past(alarmWord)));
endmodule

bind cal_clock_top cal_clock_checker uChk (
  .clk(clk), .rstN(rstN), .tickIn(tickIn), .loadTimeEn(loadTimeEn),
  .loadTimeVal(loadTimeVal), .timeOut(timeOut), .alarmWord(alarmWord),
  .secEvt(secEvt), .minEvt(minEvt), .hourEvt(hourEvt), .dayEvt(dayEvt),
  .todAlarmEvt(todAlarmEvt), .dayAlarmEvt(dayAlarmEvt));

// File: tb/tb_cal_clock_top.sv
module tb_cal_clock_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        loadTimeEn = 1'b0;
  logic [31:0] loadTimeVal = '0;
  logic        loadAlarmEn = 1'b0;
  logic [31:0] loadAlarmVal = '0;
  logic [31:0] timeOut;
  logic        secEvt, minEvt, hourEvt, dayEvt, todAlarmEvt, dayAlarmEvt;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cal_clock_top dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .loadTimeEn(loadTimeEn),
    .loadTimeVal(loadTimeVal), .loadAlarmEn(loadAlarmEn),
    .loadAlarmVal(loadAlarmVal), .timeOut(timeOut),
    .secEvt(secEvt), .minEvt(minEvt), .hourEvt(hourEvt), .dayEvt(dayEvt),
    .todAlarmEvt(todAlarmEvt), .dayAlarmEvt(dayAlarmEvt));

  // event vector order: {dayAlarm, todAlarm, day, hour, min, sec}
  function automatic logic [5:0] evts();
    return {dayAlarmEvt, todAlarmEvt, dayEvt, hourEvt, minEvt, secEvt};
  endfunction

  function automatic logic [31:0] pk(int d, int h, int m, int s);
    return {15'(d), 5'(h), 6'(m), 6'(s)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] start;
    logic [31:0] alarm;
    logic [31:0] expT;
    logic [5:0]  expEv;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{ {15'd0, 5'd0, 6'd0, 6'd0},      {15'd5, 5'd1, 6'd1, 6'd1},    {15'd0, 5'd0, 6'd0, 6'd1},    6'b000001 }, // R2
    '{ {15'd0, 5'd0, 6'd0, 6'd59},     {15'd9, 5'd9, 6'd9, 6'd9},    {15'd0, 5'd0, 6'd1, 6'd0},    6'b000011 }, // R3
    '{ {15'd0, 5'd0, 6'd59, 6'd59},    {15'd9, 5'd9, 6'd9, 6'd9},    {15'd0, 5'd1, 6'd0, 6'd0},    6'b000111 }, // R4
    '{ {15'd3, 5'd23, 6'd59, 6'd59},   {15'd9, 5'd9, 6'd9, 6'd9},    {15'd4, 5'd0, 6'd0, 6'd0},    6'b001111 }, // R5
    '{ {15'd32767, 5'd23, 6'd59, 6'd59},{15'd9, 5'd9, 6'd9, 6'd9},   {15'd0, 5'd0, 6'd0, 6'd0},    6'b001111 }, // R6
    '{ {15'd2, 5'd10, 6'd20, 6'd29},   {15'd7, 5'd10, 6'd20, 6'd30}, {15'd2, 5'd10, 6'd20, 6'd30}, 6'b010001 }, // R8
    '{ {15'd7, 5'd10, 6'd20, 6'd29},   {15'd7, 5'd10, 6'd20, 6'd30}, {15'd7, 5'd10, 6'd20, 6'd30}, 6'b110001 }, // R9
    '{ {15'd1, 5'd5, 6'd10, 6'd62},    {15'd9, 5'd9, 6'd9, 6'd9},    {15'd1, 5'd5, 6'd11, 6'd0},   6'b000011 }, // R7
    '{ {15'd1, 5'd30, 6'd59, 6'd59},   {15'd9, 5'd9, 6'd9, 6'd9},    {15'd2, 5'd0, 6'd0, 6'd0},    6'b001111 }  // R7
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 time after reset", timeOut, 32'd0);
    chk("R1 events after reset", 32'(evts()), 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      loadTimeEn = 1'b1; loadTimeVal = VECS[i].start;
      loadAlarmEn = 1'b1; loadAlarmVal = VECS[i].alarm;
      @(negedge clk);
      loadTimeEn = 1'b0; loadAlarmEn = 1'b0;
      chk("R11 loaded value", timeOut, VECS[i].start);
      chk("R11 load silent", 32'(evts()), 32'd0);
      tickIn = 1'b1;
      @(negedge clk);
      tickIn = 1'b0;
      chk("R2-R9 table time", timeOut, VECS[i].expT);
      chk("R2-R9 table events", 32'(evts()), 32'(VECS[i].expEv));
      @(negedge clk);
      chk("R10 pulses cleared", 32'(evts()), 32'd0);
    end

    // R11: load wins over tick in the same cycle
    loadTimeEn = 1'b1; loadTimeVal = pk(0, 1, 2, 3); tickIn = 1'b1;
    @(negedge clk);
    loadTimeEn = 1'b0; tickIn = 1'b0;
    chk("R11 load beats tick", timeOut, pk(0, 1, 2, 3));
    chk("R11 no event with tick", 32'(evts()), 32'd0);

    // R12: hold without tick, alarm load leaves time alone
    held = timeOut;
    repeat (5) @(negedge clk);
    chk("R12 hold", timeOut, held);
    loadAlarmEn = 1'b1; loadAlarmVal = pk(0, 1, 2, 5);
    @(negedge clk);
    loadAlarmEn = 1'b0;
    chk("R12 alarm load keeps time", timeOut, held);
    chk("R12 alarm load no event", 32'(evts()), 32'd0);

    // R8/R9/R10: approach alarm tick by tick
    tickIn = 1'b1; @(negedge clk); tickIn = 1'b0;
    chk("R2 second tick", timeOut, pk(0, 1, 2, 4));
    chk("R8 no early alarm", 32'(evts()), 32'b000001);
    tickIn = 1'b1; @(negedge clk); tickIn = 1'b0;
    chk("R9 both alarms", 32'(evts()), 32'b110001);
    @(negedge clk);
    chk("R10 alarm single cycle", 32'(evts()), 32'd0);
    tickIn = 1'b1; @(negedge clk); tickIn = 1'b0;
    chk("R10 alarm not repeated", 32'(evts()), 32'b000001);

    // R11: loading a value equal to the alarm raises nothing
    loadTimeEn = 1'b1; loadTimeVal = pk(0, 1, 2, 5);
    @(negedge clk);
    loadTimeEn = 1'b0;
    chk("R11 load equal alarm silent", 32'(evts()), 32'd0);

    // R2: tick held for three cycles counts three seconds
    tickIn = 1'b1;
    repeat (3) @(negedge clk);
    tickIn = 1'b0;
    chk("R2 consecutive ticks", timeOut, pk(0, 1, 2, 8));

    finish_run();
  end
endmodule